// File: doc/BRIEF.md
# Store Lane Aligner

This block sits between the load/store stage of a 32-bit processor and a synchronous data memory that has no wait states. Each cycle it may take one store request. A request carries a byte address, a size code and register data.

One clock later the block presents the memory-side signals:

- the word-aligned address;
- the data copied into the byte lanes that the low address bits select;
- a byte-write-enable mask with one bit per lane;
- a write strobe.

The memory commits the write on the rising edge that follows.

A halfword at an odd address, or a word that is not on a 4-byte boundary, is not written. The strobe and mask stay low, and a one-cycle misaligned-store flag is raised instead so the core can trap.

Top module: `store_align`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `mem_wreq` is 0, `mem_wmask` is 4'b0000 and `st_misaligned` is 0.
- R2: A valid, aligned store sampled at a rising edge drives `mem_wreq` high for exactly the following cycle. Whenever `mem_wreq` is low, `mem_wmask` is 4'b0000.
- R3: During a write, `mem_addr` equals the request address with bits 1:0 cleared.
- R4: A word store (size 2'b10, or 2'b11, which is treated as word) enables mask 4'b1111 and passes the data unchanged.
- R5: A halfword store (size 2'b01) enables mask 4'b0011 when addr[1]=0 and 4'b1100 when addr[1]=1. Data bits 15:0 appear in both bits 15:0 and bits 31:16.
- R6: A byte store (size 2'b00) enables only mask bit addr[1:0], where bit 0 covers data bits 7:0. Data bits 7:0 appear in all four byte lanes.
- R7: A halfword store with addr[0]=1, or a word store with addr[1:0]≠0, raises `st_misaligned` for one cycle and forces `mem_wreq`=0 and `mem_wmask`=4'b0000. A byte store is never misaligned.
- R8: A cycle with `st_valid` low produces no write and no misaligned flag on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| st_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| st_data | input | 32 | Register data, right-justified |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_wmask | output | 4 | Byte-write enables, bit i for bits 8i+7:8i |
| mem_wreq | output | 1 | Write strobe to memory |
| st_misaligned | output | 1 | Store address misaligned, one-cycle pulse |

## Verification
The assertions assume that reset lasts more than one edge and that the request inputs are driven to known values on every edge. This lets `$past` on the size and valid inputs reflect a real request, or an idle cycle. The bench drives every input in each cycle from random values with a fixed seed, away from the clock edge. It holds `st_valid` low during reset, and adds directed cases for each lane offset and each misaligned form. A small memory model applies the mask and address on each write, so that the merged word contents can be compared with a shadow copy at the end.

// File: rtl/store_align.sv
module store_align #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic [31:0]       st_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wmask,
  output logic              mem_wreq,
  output logic              st_misaligned
);
  localparam int LANES = 4;

  logic [1:0]       ofs;
  logic             sz_byte, sz_half, sz_word, bad, go;
  logic [LANES-1:0] lane_en;
  logic [31:0]      lane_data;

  assign ofs     = st_addr[1:0];
  assign sz_byte = (st_size == 2'b00);
  assign sz_half = (st_size == 2'b01);
  assign sz_word = st_size[1];
  assign bad     = st_valid && ((sz_half && ofs[0]) || (sz_word && ofs != 2'b00));
  assign go      = st_valid && !bad;

  always_comb begin
    if (sz_word)      lane_en = 4'b1111;
    else if (sz_half) lane_en = ofs[1] ? 4'b1100 : 4'b0011;
    else              lane_en = 4'b0001 << ofs;
  end

  assign lane_data = sz_byte ? {4{st_data[7:0]}} :
                     sz_half ? {2{st_data[15:0]}} : st_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_wreq      <= 1'b0;
      mem_wmask     <= '0;
      st_misaligned <= 1'b0;
      mem_addr      <= '0;
      mem_wdata     <= '0;
    end else begin
      mem_wreq      <= go;
      mem_wmask     <= go ? lane_en : '0;
      st_misaligned <= bad;
      mem_addr      <= {st_addr[ADDR_W-1:2], 2'b00};
      mem_wdata     <= lane_data;
    end
  end
endmodule

module store_align_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic [1:0]        st_size,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_wmask,
  input logic              mem_wreq,
  input logic              st_misaligned
);
  // R8
  write_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wreq |-> $past(st_valid));
  // R7
  misalign_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_misaligned |-> (!mem_wreq && mem_wmask == 4'b0000));
  // R2
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wreq |-> mem_wmask == 4'b0000);
  // R3
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wreq |-> mem_addr[1:0] == 2'b00);
  // R6
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wreq |-> ($countones(mem_wmask) == 1 || $countones(mem_wmask) == 2 ||
                  $countones(mem_wmask) == 4));
  // R4
  word_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wreq && $past(st_size[1])) |-> mem_wmask == 4'b1111);
endmodule

bind store_align store_align_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_size(st_size),
  .mem_addr(mem_addr), .mem_wmask(mem_wmask), .mem_wreq(mem_wreq),
  .st_misaligned(st_misaligned)
);

// File: tb/store_align_test.sv
`timescale 1ns/1ps
module store_align_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [1:0]    st_size = '0;
  logic [31:0]   st_data = '0;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [3:0]    mem_wmask;
  logic          mem_wreq, st_misaligned;

  int errors = 0, checks = 0;
  logic [31:0] mem [16];
  logic [31:0] shadow [16];

  logic          e_wreq = 0, e_mis = 0;
  logic [3:0]    e_mask = 0;
  logic [AW-1:0] e_addr = 0;
  logic [31:0]   e_data = 0;
  logic [1:0]    e_size = 0;

  always #2.5 clk = ~clk;

  store_align #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_size(st_size), .st_data(st_data), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_wreq(mem_wreq),
    .st_misaligned(st_misaligned)
  );

  always @(posedge clk)
    if (mem_wreq)
      for (int i = 0; i < 4; i++)
        if (mem_wmask[i]) mem[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];

  function automatic logic f_mis(logic [AW-1:0] a, logic [1:0] s);
    return (s == 2'b01 && a[0]) || (s[1] && a[1:0] != 2'b00);
  endfunction

  function automatic logic [3:0] f_mask(logic [AW-1:0] a, logic [1:0] s);
    if (s[1]) return 4'b1111;
    if (s == 2'b01) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b0001 << a[1:0];
  endfunction

  function automatic logic [31:0] f_data(logic [31:0] d, logic [1:0] s);
    if (s == 2'b00) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (s == 2'b01) return {d[15:0], d[15:0]};
    return d;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string size_tag(logic [1:0] s);
    if (s[1]) return "R4 word";
    if (s == 2'b01) return "R5 halfword";
    return "R6 byte";
  endfunction

  task automatic step(input logic v, input logic [AW-1:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    check(mem_wreq == e_wreq, "R2/R8 wreq", {31'b0, mem_wreq}, {31'b0, e_wreq});
    check(mem_wmask == e_mask, e_mis ? "R7 mask" : "R2 mask", {28'b0, mem_wmask}, {28'b0, e_mask});
    check(st_misaligned == e_mis, "R7 flag", {31'b0, st_misaligned}, {31'b0, e_mis});
    if (e_wreq) begin
      check(mem_addr == e_addr, "R3 addr", mem_addr, e_addr);
      check(mem_wdata == e_data, size_tag(e_size), mem_wdata, e_data);
    end
    e_mis  = v && f_mis(a, s);
    e_wreq = v && !e_mis;
    e_mask = e_wreq ? f_mask(a, s) : 4'b0000;
    e_addr = {a[AW-1:2], 2'b00};
    e_data = f_data(d, s);
    e_size = s;
    if (e_wreq)
      for (int i = 0; i < 4; i++)
        if (e_mask[i]) shadow[a[5:2]][8*i +: 8] = e_data[8*i +: 8];
    st_valid = v; st_addr = a; st_size = s; st_data = d;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    // R1
    check(!mem_wreq && mem_wmask == 0 && !st_misaligned, "R1 reset", {28'b0, mem_wmask}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_wreq && mem_wmask == 0 && !st_misaligned, "R1 after reset", {28'b0, mem_wmask}, 32'h0);
    // directed: word, halfword upper/lower, each byte lane (R4, R5, R6)
    step(1, 32'h0000_0010, 2'b10, 32'h1234_5678);
    step(1, 32'h0000_0012, 2'b01, 32'h0000_ABCD);
    step(1, 32'h0000_0011, 2'b00, 32'h0000_00EF);
    step(1, 32'h0000_0020, 2'b01, 32'h5555_7777);
    step(1, 32'h0000_0020, 2'b00, 32'h0000_0011);
    step(1, 32'h0000_0022, 2'b00, 32'h0000_0022);
    step(1, 32'h0000_0023, 2'b00, 32'h0000_0033);
    step(1, 32'hFFFF_FFFC, 2'b11, 32'hCAFE_F00D);
    // misaligned forms (R7)
    step(1, 32'h0000_0031, 2'b01, 32'hDEAD_BEEF);
    step(1, 32'h0000_0033, 2'b01, 32'hDEAD_BEEF);
    step(1, 32'h0000_0032, 2'b10, 32'hDEAD_BEEF);
    step(1, 32'h0000_0031, 2'b11, 32'hDEAD_BEEF);
    // idle with garbage inputs (R8)
    step(0, 32'h0000_0030, 2'b10, 32'hDEAD_BEEF);
    step(0, 32'h0000_0031, 2'b01, 32'h0BAD_0BAD);
    for (int n = 0; n < 2000; n++)
      step(($urandom % 4) != 0, $urandom, 2'($urandom), $urandom);
    step(0, '0, 2'b00, '0);
    step(0, '0, 2'b00, '0);
    @(negedge clk);
    // memory merge after many lane writes (R4, R5, R6)
    for (int i = 0; i < 16; i++)
      check(mem[i] == shadow[i], "R6/R5/R4 merged memory", mem[i], shadow[i]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule